// File: doc/BRIEF.md
# GPIO Pin Event Detector

This block watches a vector of general-purpose input pins and turns selected activity on each pin into a sticky status bit. Each pin has six enables that can be used in any combination. Four of them work on a synchronized copy of the pin: rising edge, falling edge, high level and low level. The other two catch rising or falling edges without clock sampling, so a pulse narrower than a clock period is not lost. All enabled conditions for a pin feed one status bit. One interrupt line reports that at least one status bit is set.

Software reaches the block through a 32-bit write port. A selector picks one of the six enable banks or the status-clear action. A word index picks which 32-pin slice is written, and a data word carries one bit per pin. The status bits are driven continuously as 32-bit words, so a register decoder above this block can return them on a read.

Top module: `gpio_evt_det`

## Requirements
- R1: While rst_ni is low, and after it, all status bits, all six enable banks and irq_o are 0. With every enable at 0, no pin activity sets any status bit.
- R2: With its rising enable set, a pin that goes from 0 to 1 sets its status bit. If the new level is first sampled at clock edge n, the bit reads 1 after edge n+2. A pulse that covers no rising clock edge is not seen by this path.
- R3: With its falling enable set, a pin that goes from 1 to 0 sets its status bit, with the same latency as R2.
- R4: With its high enable set, a pin that is high sets its status bit on every cycle in which the synchronized level is 1. The bit therefore comes back one cycle after a clear while the level lasts.
- R5: With its low enable set, a pin that is low sets its status bit on every cycle in which the synchronized level is 0.
- R6: With its asynchronous rising enable set, a rising pin edge that falls between two clock edges sets the status bit after the third rising clock edge that follows it. This holds even if the pin returns low before the next clock edge. Each captured edge produces exactly one set.
- R7: The asynchronous falling enable catches a falling pin edge in the same way and with the same latency as R6.
- R8: Writing cfg_sel_i=6 clears every status bit of the addressed word whose data bit is 1 and leaves the bits written as 0 unchanged. If a set condition for a bit is present in the same cycle as its clear, the bit stays 1.
- R9: irq_o is 1 exactly when at least one status bit is 1, and it changes in the same cycle as the status.
- R10: A write with cfg_sel_i 0..5 (0 rising, 1 falling, 2 high, 3 low, 4 asynchronous rising, 5 asynchronous falling) replaces one 32-bit word of that enable bank. Bit b of word w belongs to pin 32*w+b. Data bits that map to pins at NUM_PINS or above are dropped. cfg_sel_i=7 has no effect. status_o bit 32*w+b is pin 32*w+b, and the status bits at NUM_PINS and above always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | NUM_PINS | Raw pin levels, asynchronous to clk_i |
| cfg_we_i | input | 1 | Write strobe, one cycle per write |
| cfg_sel_i | input | 3 | Write target: enable bank 0..5, 6 status clear, 7 none |
| cfg_word_i | input | WIDX_W | Index of the 32-pin word being written |
| cfg_wdata_i | input | WORD_W | One bit per pin of the addressed word |
| status_o | output | NUM_WORDS*WORD_W | Sticky per-pin event status, word 0 in the low bits |
| irq_o | output | 1 | OR of all status bits |

## Verification
A synchronizer stage that is stuck or skipped moves the status rise of a sampled edge by one cycle. The cycle-by-cycle comparison catches this within three clock edges of the pin change. A capture flop that fails to re-arm, or that fires twice, shows as a missing or repeated status set after a clear, within four cycles of the pulse. A corrupted enable word or a wrong pin-to-bit mapping shows on status_o at the first pin transition or level in that word, and irq_o follows on the same edge.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int NUM_EN = 6;

  localparam int IDX_RISE  = 0;
  localparam int IDX_FALL  = 1;
  localparam int IDX_HIGH  = 2;
  localparam int IDX_LOW   = 3;
  localparam int IDX_ARISE = 4;
  localparam int IDX_AFALL = 5;

  typedef enum logic [2:0] {
    SEL_RISE  = 3'd0,
    SEL_FALL  = 3'd1,
    SEL_HIGH  = 3'd2,
    SEL_LOW   = 3'd3,
    SEL_ARISE = 3'd4,
    SEL_AFALL = 3'd5,
    SEL_CLEAR = 3'd6,
    SEL_NONE  = 3'd7
  } cfg_sel_e;
endpackage

// File: rtl/gpio_evt_cfg.sv
module gpio_evt_cfg
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 53,
  parameter int WORD_W   = 32,
  parameter int WIDX_W   = 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [2:0]                       sel_i,
  input  logic [WIDX_W-1:0]                word_i,
  input  logic [WORD_W-1:0]                wdata_i,
  output logic [NUM_EN-1:0][NUM_PINS-1:0]  en_o,
  output logic [NUM_PINS-1:0]              wmask_o,
  output logic [NUM_PINS-1:0]              wbits_o
);

  logic [NUM_EN-1:0][NUM_PINS-1:0] en_q;

  // spread the addressed word onto the pin vector
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      wmask_o[p] = (word_i == WIDX_W'(p / WORD_W));
      wbits_o[p] = wdata_i[p % WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (we_i) begin
      for (int e = 0; e < NUM_EN; e++) begin
        if (sel_i == 3'(e)) en_q[e] <= (en_q[e] & ~wmask_o) | (wbits_o & wmask_o);
      end
    end
  end

  assign en_o = en_q;

  AST_CFG_RISE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_RISE) |=> ((en_q[IDX_RISE] & $past(wmask_o)) == $past(wbits_o & wmask_o))); // R10

  AST_CFG_NONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_NONE) |=> $stable(en_q)); // R10

endmodule

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int NUM_PINS = 53
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o
);

  logic [NUM_PINS-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_q & ~prev_q;
  assign fall_o = ~lvl_q & prev_q;

endmodule

// File: rtl/gpio_evt_acap.sv
module gpio_evt_acap #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic en_i,
  output logic evt_o
);

  logic cap_q, clr;
  logic s1_q, s2_q, s3_q, ack_q;

  // capture flop is reset by reset or by the acknowledge from the clock domain
  assign clr = ack_q | ~rst_ni;

  if (FALLING) begin : g_fall
    always_ff @(negedge pin_i or posedge clr) begin
      if (clr)       cap_q <= 1'b0;
      else if (en_i) cap_q <= 1'b1;
    end
  end else begin : g_rise
    always_ff @(posedge pin_i or posedge clr) begin
      if (clr)       cap_q <= 1'b0;
      else if (en_i) cap_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      s1_q  <= cap_q;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      ack_q <= s2_q;
    end
  end

  assign evt_o = s2_q & ~s3_q;

  AST_ACAP_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o); // R6

  AST_ACAP_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |=> ##1 !s1_q); // R7

endmodule

// File: rtl/gpio_evt_det.sv
module gpio_evt_det
  import gpio_evt_pkg::*;
#(
  parameter  int NUM_PINS  = 53,
  parameter  int WORD_W    = 32,
  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int FLAT_W    = NUM_WORDS * WORD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                cfg_we_i,
  input  logic [2:0]          cfg_sel_i,
  input  logic [WIDX_W-1:0]   cfg_word_i,
  input  logic [WORD_W-1:0]   cfg_wdata_i,
  output logic [FLAT_W-1:0]   status_o,
  output logic                irq_o
);

  logic [NUM_EN-1:0][NUM_PINS-1:0] en;
  logic [NUM_PINS-1:0] wmask, wbits;
  logic [NUM_PINS-1:0] lvl, rise, fall, arise_evt, afall_evt;
  logic [NUM_PINS-1:0] set_vec, clr_vec, status_q;
  logic                set_any, clr_any;

  gpio_evt_cfg #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .word_i  (cfg_word_i),
    .wdata_i (cfg_wdata_i),
    .en_o    (en),
    .wmask_o (wmask),
    .wbits_o (wbits)
  );

  gpio_evt_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pins_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_evt_acap #(.FALLING(1'b0)) u_arise (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins_i[p]),
      .en_i   (en[IDX_ARISE][p]),
      .evt_o  (arise_evt[p])
    );
    gpio_evt_acap #(.FALLING(1'b1)) u_afall (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins_i[p]),
      .en_i   (en[IDX_AFALL][p]),
      .evt_o  (afall_evt[p])
    );
  end

  assign set_vec = (en[IDX_RISE] & rise) | (en[IDX_FALL] & fall)
                 | (en[IDX_HIGH] & lvl)  | (en[IDX_LOW]  & ~lvl)
                 | arise_evt | afall_evt;
  assign clr_vec = (cfg_we_i && cfg_sel_i == SEL_CLEAR) ? (wbits & wmask) : '0;
  assign set_any = |set_vec;
  assign clr_any = |clr_vec;

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_vec) | set_vec;
  end

  assign status_o = FLAT_W'(status_q);
  assign irq_o    = |status_q;

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_any |=> ((status_q & $past(status_q)) == $past(status_q))); // R8

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_any |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R8

  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_any |=> ((status_q & $past(clr_vec & ~set_vec)) == '0)); // R8

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(set_any)); // R9

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(clr_any)); // R9

endmodule

// File: tb/gpio_evt_det_tb_top.sv
`timescale 1ns/1ps
module gpio_evt_det_tb_top;
  localparam int NP = 53;
  localparam int FW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          we = 1'b0;
  logic [2:0]    sel = 3'd0;
  logic [0:0]    word = 1'b0;
  logic [31:0]   wdata = '0;
  logic [FW-1:0] status;
  logic          irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  gpio_evt_det dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .cfg_we_i(we), .cfg_sel_i(sel),
    .cfg_word_i(word), .cfg_wdata_i(wdata), .status_o(status), .irq_o(irq)
  );

  // reference model
  logic [NP-1:0] m_en [6];
  logic [NP-1:0] m_stat;
  logic [NP-1:0] hist [$];
  int ar_cnt [NP];
  int af_cnt [NP];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < 6; e++) m_en[e] = '0;
      m_stat = '0;
      hist = '{'0, '0, '0};
      for (int k = 0; k < NP; k++) begin ar_cnt[k] = 0; af_cnt[k] = 0; end
    end else begin
      logic [NP-1:0] cur, old, s, c, wv;
      cur = hist[1];
      old = hist[0];
      s = (m_en[0] & cur & ~old) | (m_en[1] & ~cur & old) | (m_en[2] & cur) | (m_en[3] & ~cur);
      for (int k = 0; k < NP; k++) begin
        if (ar_cnt[k] > 0) begin ar_cnt[k]--; if (ar_cnt[k] == 0) s[k] = 1'b1; end
        if (af_cnt[k] > 0) begin af_cnt[k]--; if (af_cnt[k] == 0) s[k] = 1'b1; end
      end
      c = '0;
      wv = m_stat;
      if (we) begin
        for (int b = 0; b < 32; b++) begin
          int pn;
          pn = 32 * int'(word) + b;
          if (pn < NP) begin
            if (sel == 3'd6 && wdata[b]) c[pn] = 1'b1;
            if (sel < 3'd6) m_en[sel][pn] = wdata[b];
          end
        end
      end
      m_stat = (wv & ~c) | s;
      hist.push_back(pins);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      checks++;
      if (status !== FW'(m_stat)) begin
        errors++;
        $display("FAIL %s status actual=%h expected=%h", cur_req, status, FW'(m_stat));
      end
      checks++;
      if (irq !== (|m_stat)) begin
        errors++;
        $display("FAIL R9 irq actual=%b expected=%b", irq, |m_stat);
      end
    end
  end

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] s, input logic w, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; word = w; wdata = d;
    @(negedge clk);
    we = 1'b0; sel = 3'd0; wdata = '0;
  endtask

  task automatic set_pin(input int k, input logic v);
    @(negedge clk);
    if (v && !pins[k] && m_en[4][k]) ar_cnt[k] = 3;
    if (!v && pins[k] && m_en[5][k]) af_cnt[k] = 3;
    pins[k] = v;
  endtask

  // pulse between clock edges, never sampled by the clock
  task automatic pulse(input int k);
    @(negedge clk);
    #1;
    if (!pins[k]) begin
      pins[k] = 1'b1; if (m_en[4][k]) ar_cnt[k] = 3;
      #1;
      pins[k] = 1'b0; if (m_en[5][k]) af_cnt[k] = 3;
    end else begin
      pins[k] = 1'b0; if (m_en[5][k]) af_cnt[k] = 3;
      #1;
      pins[k] = 1'b1; if (m_en[4][k]) ar_cnt[k] = 3;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 reset status", status, '0);
    chk("R1 reset irq", FW'(irq), '0);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R1: no enables, activity ignored
    cur_req = "R1";
    set_pin(3, 1'b1);
    set_pin(3, 1'b0);
    idle(4);
    chk("R1 no enable no event", status, '0);

    // R2: rising on pins 0 and 35, pin 7 not enabled
    cur_req = "R2";
    wr(3'd0, 1'b0, 32'h0000_0021);
    wr(3'd0, 1'b1, 32'h0000_0008);
    @(negedge clk);
    pins[0] = 1'b1; pins[35] = 1'b1; pins[7] = 1'b1;
    idle(2);
    chk("R2 latency not yet", status, '0);
    idle(1);
    chk("R2 rising set", status, (64'd1 << 35) | 64'd1);

    // R8: zero write keeps, one write clears
    cur_req = "R8";
    wr(3'd6, 1'b1, 32'h0);
    idle(1);
    chk("R8 zero write keeps", status, (64'd1 << 35) | 64'd1);
    wr(3'd6, 1'b0, 32'h1);
    idle(1);
    chk("R8 clear word0 bit0", status, 64'd1 << 35);
    wr(3'd6, 1'b1, 32'h8);
    idle(1);
    chk("R9 all clear irq low", FW'(irq), '0);

    // R3: falling on pin 7 only
    cur_req = "R3";
    wr(3'd1, 1'b0, 32'h80);
    set_pin(7, 1'b0);
    set_pin(0, 1'b0);
    idle(4);
    chk("R3 falling set", status, 64'd1 << 7);
    wr(3'd6, 1'b0, 32'hffff_ffff);

    // R4: high level, re-sets after clear while high
    cur_req = "R4";
    set_pin(10, 1'b1);
    idle(4);
    chk("R4 no enable yet", status, '0);
    wr(3'd2, 1'b0, 32'h400);
    idle(1);
    chk("R4 high level set", status, 64'd1 << 10);
    wr(3'd6, 1'b0, 32'h400);
    chk("R8 set wins over clear", status, 64'd1 << 10);
    set_pin(10, 1'b0);
    wr(3'd2, 1'b0, 32'h0);
    wr(3'd6, 1'b0, 32'h400);
    idle(1);
    chk("R4 cleared after level gone", status, '0);

    // R5: low level on pin 52
    cur_req = "R5";
    wr(3'd3, 1'b1, 32'h0010_0000);
    idle(1);
    chk("R5 low level set", status, 64'd1 << 52);
    wr(3'd3, 1'b1, 32'h0);
    wr(3'd6, 1'b1, 32'hffff_ffff);
    idle(1);
    chk("R5 cleared", status, '0);

    // R2/R6: short pulse missed by sampled path, caught by async path
    cur_req = "R6";
    wr(3'd0, 1'b0, 32'h0010_0000);
    pulse(20);
    idle(5);
    chk("R2 short pulse not sampled", status, '0);
    wr(3'd4, 1'b0, 32'h0010_0000);
    pulse(20);
    idle(2);
    chk("R6 async latency not yet", status, '0);
    idle(1);
    chk("R6 async rising caught", status, 64'd1 << 20);
    wr(3'd6, 1'b0, 32'h0010_0000);
    idle(6);
    chk("R6 single set per edge", status, '0);
    wr(3'd4, 1'b0, 32'h0);

    // R7: async falling on pin 40
    cur_req = "R7";
    set_pin(40, 1'b1);
    idle(4);
    wr(3'd5, 1'b1, 32'h100);
    pulse(40);
    idle(4);
    chk("R7 async falling caught", status, 64'd1 << 40);
    wr(3'd5, 1'b1, 32'h0);
    wr(3'd6, 1'b1, 32'hffff_ffff);
    idle(8);

    // R10: selector 7 has no effect
    cur_req = "R10";
    wr(3'd7, 1'b0, 32'hffff_ffff);
    set_pin(1, 1'b1);
    idle(5);
    chk("R10 selector 7 ignored", status, '0);

    // R10: upper word mapping, bits past the last pin read zero
    wr(3'd2, 1'b1, 32'hffff_ffff);
    idle(2);
    chk("R10 word1 high map", status, (64'd1 << 35) | (64'd1 << 40));
    chk("R10 unused bits zero", FW'(status[63:53]), '0);
    chk("R9 irq high", FW'(irq), 64'd1);
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule